// File: doc/BRIEF.md
# Cached-Top LIFO Stack Unit

This block is the operand stack of a small stack-machine core. The item on top of the stack sits in its own register. Every deeper item lives in a synchronous RAM whose single write port and single read port use one shared address. That address always points at the slot that will hold the second item once the current operation completes. The RAM reads on every clock. When a read and a write hit the same word, the read returns the data just written. The registered read output is therefore always the second item, and an operation never waits for a read cycle.

Each clock the block accepts one of five operations on a 3-bit code: push, pop, replace top, swap the top two, or no-op. The outputs show the top item, the second item and the number of valid entries, where the top register counts as one entry. A push into a full stack raises an overflow flag and a pop from an empty stack raises an underflow flag. Both flags stay set until a clear input or reset, and the core's status register reports them.

Top module: `stack_cached_top`

## Requirements
- R1: After reset the occupancy is 0, both flags are clear and the top output is 0. The second-item output has no defined value until two entries exist.
- R2: Push (op 1) with fewer than DEPTH entries loads the data input into the top and moves the old top to the second-item output. The occupancy rises by one. Both outputs change on the clock edge that takes the op.
- R3: Push (op 1) with DEPTH entries sets the overflow flag and changes neither the occupancy, the top nor the second item.
- R4: Pop (op 2) with at least one entry moves the second item into the top and lowers the occupancy by one. The entry below it becomes the new second item.
- R5: Pop (op 2) with no entries sets the underflow flag and leaves the occupancy at 0.
- R6: Replace (op 3) with at least one entry loads the data input into the top and leaves the occupancy and the second item unchanged. On an empty stack it has no effect.
- R7: Swap (op 4) with at least two entries exchanges the top and the second item in one clock and leaves the occupancy unchanged. With fewer than two entries it has no effect.
- R8: Both flags stay set until the clear input is high at a clock edge. If the clear and a new overflow or underflow arrive in the same cycle, the new event wins and the flag stays set.
- R9: Op codes 0, 5, 6 and 7 are no-ops that change no output.
- R10: Deeper entries keep their values across any mix of pushes, pops, swaps and replaces. A pop always returns the item pushed most recently among those still on the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code: 0 no-op, 1 push, 2 pop, 3 replace, 4 swap |
| din_i | input | DATA_W | Data for push and replace |
| flag_clr_i | input | 1 | Clears both sticky flags |
| top_o | output | DATA_W | Top-of-stack item |
| nos_o | output | DATA_W | Second item (valid when occupancy is at least 2) |
| count_o | output | $clog2(DEPTH+1) | Number of valid entries |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
Two functions can fall in the same cycle: the flag clear and a new error event. The bench provokes this by popping an empty stack, and in a separate run by pushing into a full one, with the clear input held high on that same edge. The bench expects the flag to read set afterwards. It expects the flag to read clear only after a later clear that comes with no error. A second case is the RAM read and write landing on the same word in one clock. Swap and push do this. The bench judges it by the second-item output on the very next sample, which must already hold the old top.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_REPL = 3'd3,
    OP_SWAP = 3'd4
  } stk_op_e;
endpackage

// File: rtl/stk_ram.sv
// Synchronous single-address RAM, write-first read-during-write.
module stk_ram #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 15,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (we) rdata <= wdata;
    else         rdata <= mem[addr];
  end
endmodule

// File: rtl/stk_ctrl.sv
// Occupancy, shared RAM address, top-register select and sticky flags.
module stk_ctrl #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr,
  output logic             top_ld_din,
  output logic             top_ld_ram,
  output logic             ovf,
  output logic             unf
);
  import stk_pkg::*;

  logic [CNT_W-1:0] count_n;
  logic [CNT_W-1:0] slot;
  logic             ovf_ev, unf_ev;
  logic             is_full, is_empty, has_two;

  assign is_full  = (count == CNT_W'(DEPTH));
  assign is_empty = (count == '0);
  assign has_two  = (count >= CNT_W'(2));

  always_comb begin
    count_n    = count;
    ram_we     = 1'b0;
    top_ld_din = 1'b0;
    top_ld_ram = 1'b0;
    ovf_ev     = 1'b0;
    unf_ev     = 1'b0;
    unique case (op)
      OP_PUSH: begin
        if (is_full) ovf_ev = 1'b1;
        else begin
          count_n    = count + CNT_W'(1);
          ram_we     = !is_empty;
          top_ld_din = 1'b1;
        end
      end
      OP_POP: begin
        if (is_empty) unf_ev = 1'b1;
        else begin
          count_n    = count - CNT_W'(1);
          top_ld_ram = 1'b1;
        end
      end
      OP_REPL: top_ld_din = !is_empty;
      OP_SWAP: begin
        ram_we     = has_two;
        top_ld_ram = has_two;
      end
      default: ;
    endcase
  end

  // Address of the second item after this operation completes.
  always_comb begin
    slot     = (count_n >= CNT_W'(2)) ? (count_n - CNT_W'(2)) : '0;
    ram_addr = slot[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      count <= count_n;
      ovf   <= ovf_ev | (ovf & !flag_clr);
      unf   <= unf_ev | (unf & !flag_clr);
    end
  end
endmodule

// File: rtl/stk_top_reg.sv
// Dedicated top-of-stack register.
module stk_top_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_din,
  input  logic              ld_ram,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] top
);
  always_ff @(posedge clk) begin
    if (rst)         top <= '0;
    else if (ld_din) top <= din;
    else if (ld_ram) top <= ram_q;
  end
endmodule

// File: rtl/stack_cached_top.sv
module stack_cached_top #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WORDS = DEPTH - 1,
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              flag_clr_i,
  output logic [DATA_W-1:0] top_o,
  output logic [DATA_W-1:0] nos_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic          ram_we, ld_din, ld_ram;
  logic [AW-1:0] ram_addr;

  stk_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .op(op_i), .flag_clr(flag_clr_i),
    .count(count_o), .ram_we(ram_we), .ram_addr(ram_addr),
    .top_ld_din(ld_din), .top_ld_ram(ld_ram), .ovf(ovf_o), .unf(unf_o)
  );

  stk_ram #(.DATA_W(DATA_W), .WORDS(WORDS), .AW(AW)) u_ram (
    .clk(clk), .rst(rst), .we(ram_we), .addr(ram_addr),
    .wdata(top_o), .rdata(nos_o)
  );

  stk_top_reg #(.DATA_W(DATA_W)) u_top (
    .clk(clk), .rst(rst), .ld_din(ld_din), .ld_ram(ld_ram),
    .din(din_i), .ram_q(nos_o), .top(top_o)
  );
endmodule

// File: rtl/stk_checker.sv
module stk_checker #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] din_i,
  input logic              flag_clr_i,
  input logic [DATA_W-1:0] top_o,
  input logic [DATA_W-1:0] nos_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              ovf_o,
  input logic              unf_o
);
  import stk_pkg::*;

  p_push_r2: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_PUSH && count_o != '0 && count_o < CNT_W'(DEPTH))
      |=> (top_o == $past(din_i) && nos_o == $past(top_o) && count_o == $past(count_o) + CNT_W'(1)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_PUSH && count_o == CNT_W'(DEPTH)) |=> (ovf_o && $stable(count_o) && $stable(top_o)));

  p_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_POP && count_o >= CNT_W'(2)) |=> (top_o == $past(nos_o) && count_o == $past(count_o) - CNT_W'(1)));

  p_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_POP && count_o == '0) |=> (unf_o && count_o == '0));

  p_replace_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_REPL && count_o >= CNT_W'(2)) |=> (top_o == $past(din_i) && $stable(nos_o) && $stable(count_o)));

  p_swap_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SWAP && count_o >= CNT_W'(2)) |=> (top_o == $past(nos_o) && nos_o == $past(top_o) && $stable(count_o)));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !flag_clr_i) |=> ovf_o);

  p_unf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (unf_o && !flag_clr_i) |=> unf_o);

  p_nop_r9: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd0 || op_i > 3'd4) |=> ($stable(count_o) && $stable(top_o)));
endmodule

bind stack_cached_top stk_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stk_checker (
  .clk(clk), .rst(rst), .op_i(op_i), .din_i(din_i), .flag_clr_i(flag_clr_i),
  .top_o(top_o), .nos_o(nos_o), .count_o(count_o), .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/test_stack_cached_top.sv
`timescale 1ns/1ps
module test_stack_cached_top;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        op_i = 3'd0;
  logic [DATA_W-1:0] din_i = '0;
  logic              flag_clr_i = 1'b0;
  logic [DATA_W-1:0] top_o, nos_o;
  logic [CNT_W-1:0]  count_o;
  logic              ovf_o, unf_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [DATA_W-1:0] mq[$];
  bit m_ovf = 1'b0;
  bit m_unf = 1'b0;

  always #4 clk = ~clk;

  stack_cached_top #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_stack_cached_top (
    .clk(clk), .rst(rst), .op_i(op_i), .din_i(din_i), .flag_clr_i(flag_clr_i),
    .top_o(top_o), .nos_o(nos_o), .count_o(count_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, "count", count_o, mq.size());
    chk(req, "ovf", ovf_o, m_ovf);
    chk(req, "unf", unf_o, m_unf);
    if (mq.size() >= 1) chk(req, "top", top_o, mq[mq.size()-1]);
    if (mq.size() >= 2) chk(req, "nos", nos_o, mq[mq.size()-2]);
  endtask

  task automatic model(logic [2:0] op, logic [DATA_W-1:0] d, bit clr);
    logic [DATA_W-1:0] t;
    if (clr) begin m_ovf = 1'b0; m_unf = 1'b0; end
    case (op)
      3'd1: if (mq.size() == DEPTH) m_ovf = 1'b1; else mq.push_back(d);
      3'd2: if (mq.size() == 0) m_unf = 1'b1; else void'(mq.pop_back());
      3'd3: if (mq.size() > 0) mq[mq.size()-1] = d;
      3'd4: if (mq.size() >= 2) begin
              t = mq[mq.size()-1];
              mq[mq.size()-1] = mq[mq.size()-2];
              mq[mq.size()-2] = t;
            end
      default: ;
    endcase
  endtask

  // Drive at falling edge, model at rising edge, sample at next falling edge.
  task automatic step(string req, logic [2:0] op, logic [DATA_W-1:0] d, bit clr);
    op_i = op; din_i = d; flag_clr_i = clr;
    @(posedge clk);
    model(op, d, clr);
    @(negedge clk);
    op_i = 3'd0; flag_clr_i = 1'b0;
    compare(req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "count", count_o, 0);
    chk("R1", "ovf", ovf_o, 0);
    chk("R1", "unf", unf_o, 0);
    chk("R1", "top", top_o, 0);
    // R7 swap and R6 replace ignored when too few entries
    step("R6", 3'd3, 16'hdead, 1'b0);
    step("R7", 3'd4, 16'h0, 1'b0);
    // R2 fill the stack
    for (int i = 0; i < DEPTH; i++) step("R2", 3'd1, 16'(16'h1000 + i * 7), 1'b0);
    step("R7", 3'd4, 16'h0, 1'b0);
    // R3 overflow, twice
    step("R3", 3'd1, 16'hbeef, 1'b0);
    step("R3", 3'd1, 16'hbeee, 1'b0);
    step("R8", 3'd0, 16'h0, 1'b0);
    // R8 clear with new overflow in same cycle: event wins
    step("R8", 3'd1, 16'h1111, 1'b1);
    step("R8", 3'd0, 16'h0, 1'b1);
    // R9 unused codes
    step("R9", 3'd5, 16'h5555, 1'b0);
    step("R9", 3'd6, 16'h6666, 1'b0);
    step("R9", 3'd7, 16'h7777, 1'b0);
    step("R6", 3'd3, 16'h4242, 1'b0);
    step("R7", 3'd4, 16'h0, 1'b0);
    // R4 drain
    for (int i = 0; i < DEPTH; i++) step("R4", 3'd2, 16'h0, 1'b0);
    // R5 underflow, then clear coinciding with another underflow
    step("R5", 3'd2, 16'h0, 1'b0);
    step("R8", 3'd2, 16'h0, 1'b1);
    step("R8", 3'd0, 16'h0, 1'b1);
    step("R6", 3'd3, 16'h9999, 1'b0);
    // R10 mixed traffic
    for (int i = 0; i < 2000; i++) begin
      int r;
      logic [2:0] op;
      r = $urandom_range(0, 99);
      op = (r < 35) ? 3'd1 : (r < 65) ? 3'd2 : (r < 78) ? 3'd4 :
           (r < 88) ? 3'd3 : 3'($urandom_range(5, 7));
      step("R10", op, 16'($urandom), ($urandom_range(0, 15) == 0));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule